// File: doc/BRIEF.md
# Circular Audio DMA Address Engine

This block produces the memory addresses for a single audio DMA channel that streams through a contiguous ring buffer. Software sets a start address and an end (protection) address. The channel then walks upward one dword at a time, issuing bursts on a simple request/acknowledge word interface. When the pointer has reached the end address and a new burst is due, it reloads the start address. This gives a self-running ring that never needs a software reload.

A period event is raised each time the running address lands on a power-of-two boundary chosen by a 4-bit boundary code. Software sees the event in a sticky status bit and, if enabled, on the interrupt pin. Software reads the live pointer, and an offset view of it, back through the same register port. Burst size and the local buffer fill level needed to start a burst are both configurable. The run bit sits in a control word written with per-bit write enables.

Top module: `ring_dma_addr_gen`

## Requirements
- R1: After reset every register reads zero, `bus_req` is low and `irq` is low.
- R2: While the run bit is 0 the pointer (register 7) follows the start address (register 0) and `bus_req` stays low. Clearing the run bit in the middle of a burst drops `bus_req` and returns the pointer to the start address.
- R3: The control word (register 4) is written with per-bit enables. The run bit is bit 0 and its enable is bit 16. Enable plus value 1 sets the bit, enable with value 0 clears it, and a write without bit 16 leaves it unchanged.
- R4: A burst length of 2^B dwords, where B is bits 2:0 of register 3, is shown on `bus_len`. It is cut to the number of dwords left before the end address (register 1).
- R5: A burst starts only when `fifo_lvl` is at least the start level coded by bits 5:4 of register 3: 0→1, 1→4, 2→8, 3→16 dwords.
- R6: Each accepted dword (`bus_req` and `bus_ack` high at a clock edge) advances the pointer by 4. A pointer equal to the end address is reloaded with the start address before the next burst starts.
- R7: With a boundary code L (bits 7:4 of register 2) nonzero, an accepted dword whose following address has its low 5+L bits all zero sets status bit 0 (register 6). L = 0 never sets it.
- R8: Writing 1 to status bit 0 clears it, writing 0 leaves it set, and a new event in the same cycle wins over the clear.
- R9: `irq` is status bit 0 AND the enable bit 0 of register 5.
- R10: Register 8 reads the pointer minus the start address, except that it reads 0 when the pointer equals the end address.
- R11: While bit 11 of register 2 (page-table mode) is 1, no burst is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fifo_lvl | input | LVL_W | Dwords free (fetch) or held (store) in the local buffer |
| bus_req | output | 1 | Burst in progress, a dword is wanted |
| bus_addr | output | ADDR_W | Address of the current dword |
| bus_len | output | LEN_W | Length in dwords of the current burst |
| bus_ack | input | 1 | Dword accepted this cycle |
| irq | output | 1 | Period interrupt |

## Verification
The bench builds the block with its defaults: 32-bit addresses, an 8-bit burst length field and an 8-bit fill level, with the period detector present. The 8-bit length reaches the 128-dword burst code, so clipping at the end address shows up on buffers smaller than one burst. The full address width lets boundary codes from 64 up to 128 bytes be struck by small buffers placed just below an aligned address. Tiny rings of four dwords drive the pointer through several reloads inside one short run.

// File: rtl/rda_pkg.sv
package rda_pkg;
   localparam int REG_A_W  = 4;
   localparam int PERIOD_W = 20;   // 5 + largest boundary code (15)

   typedef enum logic [3:0] {
      RG_BASE = 4'd0,
      RG_END  = 4'd1,
      RG_PAGE = 4'd2,
      RG_XFER = 4'd3,
      RG_CTRL = 4'd4,
      RG_IEN  = 4'd5,
      RG_STAT = 4'd6,
      RG_PTR  = 4'd7,
      RG_OFFS = 4'd8
   } reg_sel_e;

   typedef enum logic {ST_IDLE, ST_BURST} eng_st_e;

   function automatic logic [7:0] burst_dw(input logic [2:0] code);
      return 8'd1 << code;
   endfunction

   function automatic logic [4:0] start_dw(input logic [1:0] code);
      case (code)
         2'd0:    return 5'd1;
         2'd1:    return 5'd4;
         2'd2:    return 5'd8;
         default: return 5'd16;
      endcase
   endfunction
endpackage

// File: rtl/rda_regs.sv
module rda_regs
   import rda_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_A_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              period_ev,
   input  logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] base_q,
   output logic [ADDR_W-1:0] end_q,
   output logic [3:0]        limit_q,
   output logic              mmu_q,
   output logic [2:0]        burst_q,
   output logic [1:0]        thr_q,
   output logic              run_q,
   output logic              ien_q,
   output logic              stat_q
);
   logic              wr_base, wr_end, wr_page, wr_xfer, wr_ctrl, wr_ien, wr_stat;
   logic [ADDR_W-1:0] offs;

   assign wr_base = reg_we && (reg_addr == RG_BASE);
   assign wr_end  = reg_we && (reg_addr == RG_END);
   assign wr_page = reg_we && (reg_addr == RG_PAGE);
   assign wr_xfer = reg_we && (reg_addr == RG_XFER);
   assign wr_ctrl = reg_we && (reg_addr == RG_CTRL);
   assign wr_ien  = reg_we && (reg_addr == RG_IEN);
   assign wr_stat = reg_we && (reg_addr == RG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         end_q   <= '0;
         limit_q <= '0;
         mmu_q   <= 1'b0;
         burst_q <= '0;
         thr_q   <= '0;
         run_q   <= 1'b0;
         ien_q   <= 1'b0;
         stat_q  <= 1'b0;
      end else begin
         if (wr_base) base_q <= reg_wdata[ADDR_W-1:0];
         if (wr_end)  end_q  <= reg_wdata[ADDR_W-1:0];
         if (wr_page) begin
            limit_q <= reg_wdata[7:4];
            mmu_q   <= reg_wdata[11];
         end
         if (wr_xfer) begin
            burst_q <= reg_wdata[2:0];
            thr_q   <= reg_wdata[5:4];
         end
         // per-bit write enable in the upper half of the word
         if (wr_ctrl && reg_wdata[16]) run_q <= reg_wdata[0];
         if (wr_ien) ien_q <= reg_wdata[0];
         // an event in the same cycle wins over the clear
         if (period_ev)                        stat_q <= 1'b1;
         else if (wr_stat && reg_wdata[0])     stat_q <= 1'b0;
      end
   end

   always_comb begin
      offs = ptr - base_q;
      if (ptr == end_q) offs = '0;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RG_BASE: reg_rdata = 32'(base_q);
         RG_END:  reg_rdata = 32'(end_q);
         RG_PAGE: reg_rdata = {20'd0, mmu_q, 3'd0, limit_q, 4'd0};
         RG_XFER: reg_rdata = {26'd0, thr_q, 1'b0, burst_q};
         RG_CTRL: reg_rdata = {31'd0, run_q};
         RG_IEN:  reg_rdata = {31'd0, ien_q};
         RG_STAT: reg_rdata = {31'd0, stat_q};
         RG_PTR:  reg_rdata = 32'(ptr);
         RG_OFFS: reg_rdata = 32'(offs);
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rda_engine.sv
module rda_engine
   import rda_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter int LVL_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                run,
   input  logic                mmu,
   input  logic [ADDR_W-1:0]   base,
   input  logic [ADDR_W-1:0]   end_a,
   input  logic [2:0]          burst,
   input  logic [1:0]          thr,
   input  logic [LVL_W-1:0]    fifo_lvl,
   input  logic                bus_ack,
   output logic                bus_req,
   output logic [LEN_W-1:0]    bus_len,
   output logic [ADDR_W-1:0]   ptr,
   output logic                acc,
   output logic [PERIOD_W-1:0] nxt_lo
);
   eng_st_e           st_q;
   logic [ADDR_W-1:0] ptr_q;
   logic [LEN_W-1:0]  left_q, len_q, len_n, bdw;
   logic [ADDR_W-1:0] room;
   logic              go;

   assign go   = run && !mmu && (fifo_lvl >= LVL_W'(start_dw(thr)));
   assign bdw  = LEN_W'(burst_dw(burst));
   assign room = (end_a - ptr_q) >> 2;
   assign len_n = (room < ADDR_W'(bdw)) ? LEN_W'(room) : bdw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ptr_q  <= '0;
         left_q <= '0;
         len_q  <= '0;
      end else if (!run) begin
         st_q  <= ST_IDLE;
         ptr_q <= base;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (go) begin
                  if (ptr_q == end_a) begin
                     ptr_q <= base;           // ring reload
                  end else begin
                     st_q   <= ST_BURST;
                     len_q  <= len_n;
                     left_q <= len_n;
                  end
               end
            end
            default: begin
               if (bus_ack) begin
                  ptr_q  <= ptr_q + ADDR_W'(4);
                  left_q <= left_q - LEN_W'(1);
                  if (left_q == LEN_W'(1)) st_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   assign bus_req = (st_q == ST_BURST) && run;
   assign bus_len = len_q;
   assign ptr     = ptr_q;
   assign acc     = bus_req && bus_ack;
   assign nxt_lo  = ptr_q[PERIOD_W-1:0] + PERIOD_W'(4);
endmodule

// File: rtl/rda_period.sv
module rda_period
   import rda_pkg::*;
#(
   parameter bit HAS_PERIOD = 1'b1
) (
   input  logic                acc,
   input  logic [PERIOD_W-1:0] nxt_lo,
   input  logic [3:0]          limit,
   output logic                ev
);
   generate
      if (HAS_PERIOD) begin : g_on
         logic [15:0] hit;
         assign hit[0] = 1'b0;
         for (genvar l = 1; l < 16; l++) begin : g_lim
            assign hit[l] = (nxt_lo[4+l:0] == '0);
         end
         assign ev = acc && hit[limit];
      end else begin : g_off
         logic unused_in;
         assign unused_in = acc ^ (^nxt_lo) ^ (^limit);
         assign ev = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ring_dma_addr_gen.sv
module ring_dma_addr_gen
   import rda_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 8,
   parameter int LVL_W      = 8,
   parameter bit HAS_PERIOD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [LVL_W-1:0]  fifo_lvl,
   output logic              bus_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [LEN_W-1:0]  bus_len,
   input  logic              bus_ack,
   output logic              irq
);
   generate
      if (ADDR_W < PERIOD_W || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie between 20 and 32");
      end
      if (LEN_W < 8) begin : g_bad_len
         $error("LEN_W must hold a 128-dword burst");
      end
      if (LVL_W < 5) begin : g_bad_lvl
         $error("LVL_W must hold a 16-dword start level");
      end
   endgenerate

   logic [ADDR_W-1:0]   base_w, end_w, ptr_w;
   logic [3:0]          limit_w;
   logic [2:0]          burst_w;
   logic [1:0]          thr_w;
   logic                mmu_w, run_w, ien_w, stat_w, acc_w, ev_w;
   logic [PERIOD_W-1:0] nxt_w;

   rda_regs #(.ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .period_ev(ev_w),
      .ptr(ptr_w), .base_q(base_w), .end_q(end_w), .limit_q(limit_w),
      .mmu_q(mmu_w), .burst_q(burst_w), .thr_q(thr_w), .run_q(run_w),
      .ien_q(ien_w), .stat_q(stat_w)
   );

   rda_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LVL_W(LVL_W)) eng_i (
      .clk(clk), .rst_n(rst_n), .run(run_w), .mmu(mmu_w), .base(base_w),
      .end_a(end_w), .burst(burst_w), .thr(thr_w), .fifo_lvl(fifo_lvl),
      .bus_ack(bus_ack), .bus_req(bus_req), .bus_len(bus_len),
      .ptr(ptr_w), .acc(acc_w), .nxt_lo(nxt_w)
   );

   rda_period #(.HAS_PERIOD(HAS_PERIOD)) per_i (
      .acc(acc_w), .nxt_lo(nxt_w), .limit(limit_w), .ev(ev_w)
   );

   assign bus_addr = ptr_w;
   assign irq      = stat_w && ien_w;
endmodule

// File: rtl/rda_chk.sv
module rda_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_ack,
   input logic [LEN_W-1:0]  bus_len,
   input logic [ADDR_W-1:0] ptr,
   input logic              run,
   input logic              mmu,
   input logic              stat,
   input logic              ien,
   input logic              irq,
   input logic              reg_we,
   input logic [3:0]        reg_addr,
   input logic [31:0]       reg_wdata
);
   a_r2_no_req_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !bus_req);

   a_r3_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_addr == 4'd4 && reg_wdata[16]) |=> $stable(run));

   a_r4_len_range: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_len != '0 && bus_len <= LEN_W'(128)));

   a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack) |=> (!run || ptr == $past(ptr) + ADDR_W'(4)));

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat && !(reg_we && reg_addr == 4'd6 && reg_wdata[0])) |=> stat);

   a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien && stat));

   a_r11_page_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (mmu && !bus_req) |=> !bus_req);
endmodule

bind ring_dma_addr_gen rda_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
   .bus_len(bus_len), .ptr(ptr_w), .run(run_w), .mmu(mmu_w),
   .stat(stat_w), .ien(ien_w), .irq(irq), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/ring_dma_addr_gen_tb_top.sv
`timescale 1ns/1ps
module ring_dma_addr_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [31:0] reg_wdata = 32'd0;
   logic [31:0] reg_rdata;
   logic [7:0]  fifo_lvl = 8'd16;
   logic        bus_req;
   logic [31:0] bus_addr;
   logic [7:0]  bus_len;
   logic        bus_ack = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   ring_dma_addr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_lvl(fifo_lvl),
      .bus_req(bus_req), .bus_addr(bus_addr), .bus_len(bus_len),
      .bus_ack(bus_ack), .irq(irq)
   );

   typedef struct packed {
      logic [31:0] base;
      logic [31:0] endv;
      logic [3:0]  lim;
      logic [2:0]  bst;
      logic [1:0]  thr;
      logic [7:0]  fifo;
      logic [15:0] n;
      logic [7:0]  elen;
      logic [31:0] eptr;
      logic [31:0] eoff;
      logic        eirq;
   } vec_t;

   localparam vec_t VECS [4] = '{
      '{base:32'h100, endv:32'h140, lim:4'd1, bst:3'd2, thr:2'd0, fifo:8'd16,
        n:16'd5,  elen:8'd4,  eptr:32'h114, eoff:32'h14, eirq:1'b0},
      '{base:32'h100, endv:32'h140, lim:4'd1, bst:3'd7, thr:2'd0, fifo:8'd16,
        n:16'd16, elen:8'd16, eptr:32'h140, eoff:32'h0,  eirq:1'b1},
      '{base:32'h1F0, endv:32'h230, lim:4'd2, bst:3'd3, thr:2'd1, fifo:8'd4,
        n:16'd6,  elen:8'd8,  eptr:32'h208, eoff:32'h18, eirq:1'b1},
      '{base:32'h080, endv:32'h090, lim:4'd0, bst:3'd4, thr:2'd0, fifo:8'd16,
        n:16'd10, elen:8'd4,  eptr:32'h088, eoff:32'h8,  eirq:1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic cfg(input logic [31:0] b, input logic [31:0] e, input logic [3:0] l,
                      input logic [2:0] bs, input logic [1:0] th, input logic [7:0] f);
      wr(4'd4, 32'h0001_0000);
      wr(4'd6, 32'h1);
      wr(4'd0, b);
      wr(4'd1, e);
      wr(4'd2, {24'd0, l, 4'd0});
      wr(4'd3, {26'd0, th, 1'b0, bs});
      fifo_lvl = f;
   endtask

   // acknowledge exactly n dwords; the fill level drops with the last one
   task automatic run_acks(input int n, output int first_len);
      int acks = 0;
      int guard = 0;
      first_len = -1;
      while (acks < n && guard < 5000) begin
         @(negedge clk);
         if (bus_req) begin
            if (first_len < 0) first_len = int'(bus_len);
            bus_ack = 1'b1;
            acks++;
            if (acks == n) fifo_lvl = 8'd0;
         end else begin
            bus_ack = 1'b0;
         end
         guard++;
      end
      @(negedge clk);
      bus_ack = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int flen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(4'd7, d); check("R1 pointer", d, 32'h0);
      rd(4'd4, d); check("R1 control", d, 32'h0);
      rd(4'd6, d); check("R1 status", d, 32'h0);
      check("R1 bus_req", {31'd0, bus_req}, 32'h0);
      check("R1 irq", {31'd0, irq}, 32'h0);

      // R3 masked control word
      wr(4'd4, 32'h0000_0001);
      rd(4'd4, d); check("R3 write without enable ignored", d, 32'h0);
      check("R3 no request", {31'd0, bus_req}, 32'h0);
      wr(4'd4, 32'h0001_0001);
      rd(4'd4, d); check("R3 enable plus value sets", d, 32'h1);
      wr(4'd4, 32'h0001_0000);
      rd(4'd4, d); check("R3 enable alone clears", d, 32'h0);

      // R2 pointer follows start address while stopped
      wr(4'd0, 32'h300);
      rd(4'd7, d); check("R2 pointer tracks start", d, 32'h300);

      wr(4'd5, 32'h1);

      // table of ring runs: R4 R6 R7 R9 R10
      for (int i = 0; i < 4; i++) begin
         cfg(VECS[i].base, VECS[i].endv, VECS[i].lim, VECS[i].bst, VECS[i].thr, VECS[i].fifo);
         wr(4'd4, 32'h0001_0001);
         run_acks(int'(VECS[i].n), flen);
         check($sformatf("R4 burst length v%0d", i), 32'(flen), 32'(VECS[i].elen));
         rd(4'd7, d); check($sformatf("R6 pointer v%0d", i), d, VECS[i].eptr);
         rd(4'd8, d); check($sformatf("R10 offset v%0d", i), d, VECS[i].eoff);
         rd(4'd6, d); check($sformatf("R7 status v%0d", i), d, {31'd0, VECS[i].eirq});
         check($sformatf("R9 irq v%0d", i), {31'd0, irq}, {31'd0, VECS[i].eirq});
      end

      // R8 and R9: clear rules and enable gating
      cfg(32'h0, 32'h100, 4'd1, 3'd4, 2'd0, 8'd16);
      wr(4'd4, 32'h0001_0001);
      run_acks(16, flen);
      rd(4'd6, d); check("R7 event at 64-byte boundary", d, 32'h1);
      wr(4'd5, 32'h0);
      check("R9 irq gated off", {31'd0, irq}, 32'h0);
      wr(4'd5, 32'h1);
      check("R9 irq gated on", {31'd0, irq}, 32'h1);
      wr(4'd6, 32'h0);
      rd(4'd6, d); check("R8 writing zero keeps status", d, 32'h1);
      wr(4'd6, 32'h1);
      rd(4'd6, d); check("R8 writing one clears status", d, 32'h0);
      check("R8 irq after clear", {31'd0, irq}, 32'h0);

      // R5 start level
      cfg(32'h300, 32'h400, 4'd0, 3'd2, 2'd3, 8'd15);
      wr(4'd4, 32'h0001_0001);
      repeat (10) @(negedge clk);
      check("R5 level 15 below 16 holds", {31'd0, bus_req}, 32'h0);
      fifo_lvl = 8'd16;
      repeat (3) @(negedge clk);
      check("R5 level 16 starts", {31'd0, bus_req}, 32'h1);
      check("R5 address is start", bus_addr, 32'h300);

      // R11 page-table mode blocks bursts
      cfg(32'h300, 32'h400, 4'd0, 3'd2, 2'd0, 8'd16);
      wr(4'd2, 32'h800);
      wr(4'd4, 32'h0001_0001);
      repeat (10) @(negedge clk);
      check("R11 no request in page mode", {31'd0, bus_req}, 32'h0);
      rd(4'd7, d); check("R11 pointer at start", d, 32'h300);
      wr(4'd2, 32'h0);
      repeat (3) @(negedge clk);
      check("R11 request after leaving page mode", {31'd0, bus_req}, 32'h1);

      // R2 stop in the middle of a burst
      cfg(32'h300, 32'h400, 4'd0, 3'd7, 2'd0, 8'd16);
      wr(4'd4, 32'h0001_0001);
      run_acks(3, flen);
      check("R2 burst still open", {31'd0, bus_req}, 32'h1);
      wr(4'd4, 32'h0001_0000);
      check("R2 request dropped", {31'd0, bus_req}, 32'h0);
      rd(4'd7, d); check("R2 pointer back at start", d, 32'h300);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule